// File: doc/BRIEF.md
# Key Slot Allocator

This block hands out hardware key slots to clients of a cipher engine. It keeps the free slots in a first-in first-out list: an allocate request takes the oldest free slot, and a release request puts a slot back at the end of the list. One slot is held for a key loaded at boot. It is never part of the list, and a client that cannot get a slot of its own keys through that slot instead.

A grant is registered. It arrives one cycle after the allocate request and carries a success bit with the slot number. A failed grant names the reserved slot as the fallback keying slot. An occupancy bitmap sits next to the list. It catches a release of a slot that is already free, flags it, and drops it, so the list never holds the same slot twice.

Top module: `key_slot_alloc`

## Requirements
- R1: After reset `pool_empty` is 0, `grant_valid` is 0 and `rel_err` is 0. The first seven grants return slots 0, 1, 2, 3, 5, 6, 7 in that order.
- R2: Slot 4, the reserved slot, is never returned with `grant_ok` = 1.
- R3: A release that names slot 4 is ignored. `rel_err` stays 0 and the free list is unchanged.
- R4: A released slot joins the tail of the free list. Allocations take from the head, so slots come back in the order they were released.
- R5: While the free list is empty, `pool_empty` is 1. An allocation in that state returns `grant_ok` = 0 and `grant_slot` = 4, the fallback keying slot, and the list is left as it was.
- R6: An allocate and a release in the same cycle are both carried out. The head is removed first and the released slot is then added at the tail. An allocation made while the list is empty fails even if a release arrives in the same cycle, and that release is still added.
- R7: `grant_valid` is 1 exactly in the cycle after a cycle with `alloc_req` = 1, and 0 otherwise.
- R8: A release of a slot that is already free sets `rel_err` = 1 in the following cycle and adds nothing to the list. A valid release leaves `rel_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one slot |
| grant_valid | output | 1 | Grant present (one cycle after the request) |
| grant_ok | output | 1 | Grant carries a slot taken from the free list |
| grant_slot | output | 3 | Granted slot number, or the reserved slot when the grant fails |
| pool_empty | output | 1 | Free list holds no slot |
| rel_req | input | 1 | Return a slot |
| rel_slot | input | 3 | Slot number being returned |
| rel_err | output | 1 | The previous release named a slot that was already free |

## Verification
`grant_valid`, `grant_ok`, `grant_slot` and `rel_err` come from registers, so each is due one cycle after the request that causes it. `pool_empty` is combinational on the list count and follows the edge at which the list changes. The bench applies each request at the falling edge and samples 1 ns after the next rising edge, which is the cycle these outputs are due. An ignored or rejected release is judged by draining the list afterwards and comparing the slot order and the point at which the list runs empty.

// File: rtl/key_slot_alloc.sv
module key_slot_alloc #(
  parameter int NUM_SLOTS = 8,
  parameter int RSVD_SLOT = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_req,
  output logic                         grant_valid,
  output logic                         grant_ok,
  output logic [$clog2(NUM_SLOTS)-1:0] grant_slot,
  output logic                         pool_empty,
  input  logic                         rel_req,
  input  logic [$clog2(NUM_SLOTS)-1:0] rel_slot,
  output logic                         rel_err
);
  localparam int SW    = $clog2(NUM_SLOTS);
  localparam int DEPTH = NUM_SLOTS - 1;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [SW-1:0] RSVD = SW'(RSVD_SLOT);

  logic [SW-1:0]        fifo [DEPTH];
  logic [PW-1:0]        rd_ptr, wr_ptr;
  logic [CW-1:0]        count;
  logic [NUM_SLOTS-1:0] free_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire head_ok  = (count != '0);
  wire do_pop   = alloc_req && head_ok;
  wire rel_live = rel_req && (rel_slot != RSVD) && (int'(rel_slot) < NUM_SLOTS);
  wire rel_dup  = rel_live && free_q[rel_slot];
  wire do_push  = rel_live && !free_q[rel_slot];

  assign pool_empty = !head_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        fifo[i] <= (i < RSVD_SLOT) ? SW'(i) : SW'(i + 1);
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CW'(DEPTH);
      for (int s = 0; s < NUM_SLOTS; s++)
        free_q[s] <= (s != RSVD_SLOT);
      grant_valid <= 1'b0;
      grant_ok    <= 1'b0;
      grant_slot  <= RSVD;
      rel_err     <= 1'b0;
    end else begin
      grant_valid <= alloc_req;
      grant_ok    <= do_pop;
      if (alloc_req) grant_slot <= do_pop ? fifo[rd_ptr] : RSVD;
      rel_err <= rel_dup;
      if (do_pop) begin
        rd_ptr <= nxt(rd_ptr);
        free_q[fifo[rd_ptr]] <= 1'b0;
      end
      if (do_push) begin
        fifo[wr_ptr] <= rel_slot;
        wr_ptr <= nxt(wr_ptr);
        free_q[rel_slot] <= 1'b1;
      end
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r2_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ok) |-> (grant_slot != RSVD));

  a_r5_empty_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && pool_empty) |=> (grant_valid && !grant_ok && grant_slot == RSVD));

  a_r7_grant_follows: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> grant_valid);

  a_r7_no_stray_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> !grant_valid);

  a_r8_no_duplicates: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_q) == int'(count));

  a_r3_rsvd_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && rel_slot == RSVD && !alloc_req) |=> ($stable(count) && !rel_err));

  a_r8_err_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_req));
endmodule

// File: tb/key_slot_alloc_tb.sv
module key_slot_alloc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, rel_req = 1'b0;
  logic [2:0] rel_slot = 3'd0;
  logic grant_valid, grant_ok, pool_empty, rel_err;
  logic [2:0] grant_slot;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  key_slot_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
    .grant_valid(grant_valid), .grant_ok(grant_ok), .grant_slot(grant_slot),
    .pool_empty(pool_empty), .rel_req(rel_req), .rel_slot(rel_slot),
    .rel_err(rel_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic r, input logic [2:0] rs);
    @(negedge clk);
    alloc_req = a; rel_req = r; rel_slot = rs;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_grant(input string tag, input int slot);
    cyc(1'b1, 1'b0, 3'd0);
    check({tag, " R7 valid"}, grant_valid, 1);
    check({tag, " ok"}, grant_ok, 1);
    check({tag, " slot"}, grant_slot, slot);
  endtask

  task automatic expect_fail(input string tag);
    cyc(1'b1, 1'b0, 3'd0);
    check({tag, " R7 valid"}, grant_valid, 1);
    check({tag, " R5 ok"}, grant_ok, 0);
    check({tag, " R5 fallback slot"}, grant_slot, 4);
  endtask

  task automatic t_reset();
    check("R1 pool_empty", pool_empty, 0);
    check("R1 grant_valid", grant_valid, 0);
    check("R1 rel_err", rel_err, 0);
  endtask

  task automatic t_initial_order();
    int exp_list[7] = '{0, 1, 2, 3, 5, 6, 7};
    foreach (exp_list[i]) begin
      expect_grant("R1 initial order", exp_list[i]);
      check("R2 not reserved", int'(grant_slot == 3'd4), 0);
    end
    cyc(1'b0, 1'b0, 3'd0);
    check("R5 pool_empty after drain", pool_empty, 1);
    check("R7 idle no grant", grant_valid, 0);
  endtask

  task automatic t_empty();
    expect_fail("R5 empty alloc");
    check("R5 still empty", pool_empty, 1);
  endtask

  task automatic t_rsvd_release();
    cyc(1'b0, 1'b1, 3'd4);
    check("R3 no error", rel_err, 0);
    check("R3 pool unchanged", pool_empty, 1);
    cyc(1'b0, 1'b0, 3'd0);
    expect_fail("R3 nothing enqueued");
  endtask

  task automatic t_fifo();
    cyc(1'b0, 1'b1, 3'd6);
    check("R8 valid release no err", rel_err, 0);
    cyc(1'b0, 1'b1, 3'd2);
    cyc(1'b0, 1'b1, 3'd0);
    cyc(1'b0, 1'b0, 3'd0);
    check("R4 pool not empty", pool_empty, 0);
    expect_grant("R4 order 1st", 6);
    expect_grant("R4 order 2nd", 2);
    expect_grant("R4 order 3rd", 0);
    expect_fail("R4 drained");
  endtask

  task automatic t_dup();
    cyc(1'b0, 1'b1, 3'd3);
    check("R8 first release ok", rel_err, 0);
    cyc(1'b0, 1'b1, 3'd3);
    check("R8 duplicate flagged", rel_err, 1);
    cyc(1'b0, 1'b0, 3'd0);
    check("R8 err one cycle", rel_err, 0);
    expect_grant("R8 single copy", 3);
    expect_fail("R8 no duplicate queued");
  endtask

  task automatic t_simul();
    cyc(1'b1, 1'b1, 3'd5);
    check("R6 empty alloc fails", grant_ok, 0);
    check("R6 release landed", pool_empty, 0);
    expect_grant("R6 released slot granted", 5);
    cyc(1'b0, 1'b1, 3'd1);
    cyc(1'b0, 1'b1, 3'd7);
    cyc(1'b1, 1'b1, 3'd2);
    check("R6 head granted", grant_slot, 1);
    check("R6 head ok", grant_ok, 1);
    check("R6 no err", rel_err, 0);
    expect_grant("R6 next", 7);
    expect_grant("R6 tail", 2);
    expect_fail("R6 drained");
    cyc(1'b0, 1'b0, 3'd0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_initial_order();
    t_empty();
    t_rsvd_release();
    t_fifo();
    t_dup();
    t_simul();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule